// File: doc/BRIEF.md
# Pattern RAM Indirect Register Bridge

This block gives a host indirect read and write access to a 128-word by 40-bit pattern-match RAM through three 32-bit registers. The host reaches the registers over a small synchronous register port. A control register holds a lock bit, a 7-bit word address and one data byte. Two data registers each carry two more bytes in their low halves. Writes are staged in the block. The 40-bit word is written to the RAM as a single unit, and only when the last register of a fixed write order is written.

When the host writes the control register with the lock bit set, the bridge hands the RAM to a pattern matcher. It raises `match_en` and routes the matcher's address onto the RAM's only port. While the lock bit is set, host writes to the data registers have no effect. A host read then returns only the lock bit. Writing the control register with the lock bit clear gives the RAM back to the host. That same write reads the word at the new address into read shadows.

The register port has no back-pressure. A strobe is taken on the clock edge where it is high, and read data is registered. Register selects: 0 = control, 1 = low data, 2 = high data, 3 = unused.

Top module: `pat_ram_bridge`

## Requirements
- R1: After reset, `match_en` is 0, `reg_rdata` is 0, and a read of the control register returns 0.
- R2: A control write with bit 7 set raises `match_en` on the next cycle. Writes to the low and high data registers while `match_en` is 1 leave the RAM unchanged. A control write with bit 7 clear drops `match_en`.
- R3: While `match_en` is 1, a read of any select returns `32'h0000_0080`.
- R4: Writing control, then low data, then high data stores the word {high[15:0], low[15:0], control[15:8]} at control[6:0]. Control bits 15:8 land in word bits 7:0, and high data bits 15:0 land in word bits 39:24.
- R5: The RAM word does not change until the high data write. A control write followed by a low data write only, with no high data write, leaves the word unchanged.
- R6: A high data write is ignored unless a low data write has come after the most recent control write.
- R7: A control write with bit 7 clear loads the addressed word into shadows. From two cycles after that write, reads may come in any order. Select 0 returns {16'h0, word[7:0], 1'b0, address}. Select 1 returns {16'h0, word[23:8]}. Select 2 returns {16'h0, word[39:24]}.
- R8: `reg_rdata` updates only on the clock edge after `reg_rd` and holds otherwise. Its bits 31:16 are always 0, and select 3 reads as 0.
- R9: While `match_en` is 1, `match_rdata` shows the word at `match_addr` one cycle after that address is presented.
- R10: Bits 31:16 of host write data are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| reg_sel | input | 2 | Register select |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| match_en | output | 1 | Matcher owns the RAM |
| match_addr | input | 7 | Matcher read address |
| match_rdata | output | 40 | Matcher read data, one-cycle latency |

## Verification
The hardest case to reach is a write sequence that is broken off or out of order. That means a low data write followed by a new control write, or a high data write with no low data write before it. In both cases no RAM write must happen. These cases are built by deliberately skipping or reordering register writes on words that the bench first filled with a known pattern. The word is then read back through a fresh control write. A second hard case is locked mode. The bench sends data writes while locked, then reads every word through the matcher port, then unlocks and checks through host reads that nothing changed.

// File: rtl/pat_bridge_pkg.sv
package pat_bridge_pkg;
  localparam int ADDR_W   = 7;
  localparam int HALF_W   = 16;
  localparam int BYTE_W   = 8;
  localparam int WORD_W   = 2 * HALF_W + BYTE_W;
  localparam int REG_W    = 32;
  localparam int LOCK_BIT = 7;

  typedef enum logic [1:0] {
    SEL_CTL  = 2'd0,
    SEL_DLO  = 2'd1,
    SEL_DHI  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/pat_ram_sp.sv
module pat_ram_sp #(
  parameter int AW = 7,
  parameter int DW = 40
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wd,
  output logic [DW-1:0] q
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wd;
      else    q <= mem[addr];
    end
  end
endmodule

// File: rtl/pat_host_regs.sv
module pat_host_regs
  import pat_bridge_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int HW = HALF_W,
  parameter int BW = BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [1:0]        sel,
  input  logic [REG_W-1:0]  wdata,
  input  logic [2*HW+BW-1:0] ram_q,
  output logic              lock,
  output logic [AW-1:0]     addr,
  output logic [2*HW+BW-1:0] shadow,
  output logic              hreq,
  output logic              hwe,
  output logic [AW-1:0]     haddr,
  output logic [2*HW+BW-1:0] hwdata
);
  localparam int WW = 2 * HW + BW;

  logic          ctl_wr, ctl_unlock, dlo_wr, dhi_wr, commit;
  logic          lo_seen, ld_pend;
  logic [BW-1:0] stg_b0;
  logic [HW-1:0] stg_lo;

  assign ctl_wr     = wr && (sel == SEL_CTL);
  assign ctl_unlock = ctl_wr && !wdata[LOCK_BIT];
  assign dlo_wr     = wr && (sel == SEL_DLO) && !lock;
  assign dhi_wr     = wr && (sel == SEL_DHI) && !lock;
  assign commit     = dhi_wr && lo_seen;

  assign hreq   = ctl_unlock || commit;
  assign hwe    = commit;
  assign haddr  = ctl_unlock ? wdata[AW-1:0] : addr;
  assign hwdata = {wdata[HW-1:0], stg_lo, stg_b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock    <= 1'b0;
      addr    <= '0;
      stg_b0  <= '0;
      stg_lo  <= '0;
      lo_seen <= 1'b0;
      ld_pend <= 1'b0;
      shadow  <= '0;
    end else begin
      ld_pend <= ctl_unlock;
      if (ctl_wr) begin
        lock    <= wdata[LOCK_BIT];
        lo_seen <= 1'b0;
        if (!wdata[LOCK_BIT]) begin
          addr   <= wdata[AW-1:0];
          stg_b0 <= wdata[2*BW-1:BW];
        end
      end else if (dlo_wr) begin
        stg_lo  <= wdata[HW-1:0];
        lo_seen <= 1'b1;
      end else if (commit) begin
        lo_seen <= 1'b0;
      end
      if (commit)       shadow <= hwdata;
      else if (ld_pend) shadow <= ram_q;
    end
  end
endmodule

// File: rtl/pat_ram_bridge.sv
module pat_ram_bridge
  import pat_bridge_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int HW = HALF_W,
  parameter int BW = BYTE_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           reg_sel,
  input  logic                 reg_wr,
  input  logic                 reg_rd,
  input  logic [REG_W-1:0]     reg_wdata,
  output logic [REG_W-1:0]     reg_rdata,
  output logic                 match_en,
  input  logic [AW-1:0]        match_addr,
  output logic [2*HW+BW-1:0]   match_rdata
);
  localparam int WW  = 2 * HW + BW;
  localparam int PAD = REG_W - HW;

  logic          lock, hreq, hwe, ram_en;
  logic [AW-1:0] addr, haddr, ram_addr;
  logic [WW-1:0] shadow, hwdata, ram_q;
  logic          ram_we;
  logic [REG_W-1:0] rd_val;

  pat_host_regs #(.AW(AW), .HW(HW), .BW(BW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .sel(reg_sel), .wdata(reg_wdata),
    .ram_q(ram_q), .lock(lock), .addr(addr), .shadow(shadow),
    .hreq(hreq), .hwe(hwe), .haddr(haddr), .hwdata(hwdata)
  );

  assign ram_en   = hreq || lock;
  assign ram_we   = hwe;
  assign ram_addr = hreq ? haddr : match_addr;

  pat_ram_sp #(.AW(AW), .DW(WW)) u_ram (
    .clk(clk), .en(ram_en), .we(ram_we), .addr(ram_addr), .wd(hwdata), .q(ram_q)
  );

  assign match_en    = lock;
  assign match_rdata = ram_q;

  always_comb begin
    rd_val = '0;
    if (lock) begin
      rd_val[LOCK_BIT] = 1'b1;
    end else begin
      case (reg_sel)
        SEL_CTL: rd_val = {{(REG_W-2*BW){1'b0}}, shadow[BW-1:0], 1'b0,
                           {(BW-1-AW){1'b0}}, addr};
        SEL_DLO: rd_val = {{PAD{1'b0}}, shadow[BW+HW-1:BW]};
        SEL_DHI: rd_val = {{PAD{1'b0}}, shadow[WW-1:BW+HW]};
        default: rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_val;
  end
endmodule

// File: rtl/pat_bridge_chk.sv
module pat_bridge_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  reg_sel,
  input logic        reg_wr,
  input logic        reg_rd,
  input logic [31:0] reg_wdata,
  input logic [31:0] reg_rdata,
  input logic        match_en,
  input logic        ram_we
);
  AST_LOCK_FOLLOWS_CTL: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == 2'd0) |=> (match_en == $past(reg_wdata[7]))); // R2

  AST_LOCKED_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && match_en) |=> (reg_rdata == 32'h0000_0080)); // R3

  AST_RAM_WRITE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (reg_wr && reg_sel == 2'd2 && !match_en)); // R4

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> $stable(reg_rdata)); // R8

  AST_RDATA_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[31:16] == 16'h0); // R8
endmodule

bind pat_ram_bridge pat_bridge_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
  .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .match_en(match_en), .ram_we(ram_we)
);

// File: tb/tb_pat_ram_bridge.sv
module tb_pat_ram_bridge;
  localparam int CLK_PERIOD = 10;
  localparam int NWORDS = 128;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  reg_sel = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        match_en;
  logic [6:0]  match_addr = '0;
  logic [39:0] match_rdata;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pat_ram_bridge dut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .match_en(match_en), .match_addr(match_addr), .match_rdata(match_rdata)
  );

  function automatic logic [39:0] pat(input int a, input int salt);
    logic [7:0] x;
    x = 8'(a);
    return {x ^ 8'(salt), 8'(x * 3 + 1), ~x, 8'(x + 8'(salt)), 8'(x * 7)};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd_reg(input logic [1:0] s, output logic [31:0] v);
    @(negedge clk);
    reg_sel = s; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    v = reg_rdata;
  endtask

  task automatic write_word(input int a, input logic [39:0] w, input logic [15:0] junk);
    wr_reg(2'd0, {junk, w[7:0], 1'b0, 7'(a)});
    wr_reg(2'd1, {junk, w[23:8]});
    wr_reg(2'd2, {junk, w[39:24]});
  endtask

  task automatic read_word(input int a, input int order, output logic [39:0] w, output logic [31:0] c);
    logic [31:0] v0, v1, v2;
    wr_reg(2'd0, {24'h0, 1'b0, 7'(a)});
    @(negedge clk);
    case (order)
      0: begin rd_reg(2'd0, v0); rd_reg(2'd1, v1); rd_reg(2'd2, v2); end
      1: begin rd_reg(2'd2, v2); rd_reg(2'd0, v0); rd_reg(2'd1, v1); end
      default: begin rd_reg(2'd1, v1); rd_reg(2'd2, v2); rd_reg(2'd0, v0); end
    endcase
    w = {v2[15:0], v1[15:0], v0[15:8]};
    c = {v0[31:16] | v1[31:16] | v2[31:16], 9'h0, v0[6:0]};
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, c, v_hold;
    logic [39:0] w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 match_en", 64'(match_en), 64'h0);
    check("R1 rdata", 64'(reg_rdata), 64'h0);
    rd_reg(2'd0, v);
    check("R1 ctl read", 64'(v), 64'h0);

    // R4 R10 fill every word, junk in upper write bits
    for (int a = 0; a < NWORDS; a++) write_word(a, pat(a, 5), 16'hDEAD);

    // R7 read back in rotating order, R4 layout
    for (int a = 0; a < NWORDS; a++) begin
      read_word(a, a % 3, w, c);
      check("R4 R10 word", 64'(w), 64'(pat(a, 5)));
      check("R7 addr field", 64'(c), 64'(a));
    end

    // R8 select 3 and hold
    rd_reg(2'd3, v);
    check("R8 select3", 64'(v), 64'h0);
    rd_reg(2'd1, v_hold);
    repeat (4) @(negedge clk);
    check("R8 hold", 64'(reg_rdata), 64'(v_hold));

    // R5 interrupted sequence: ctl, low, then ctl again
    wr_reg(2'd0, {16'h0, 8'hA5, 1'b0, 7'd5});
    wr_reg(2'd1, 32'h0000_1234);
    read_word(5, 0, w, c);
    check("R5 no commit before high", 64'(w), 64'(pat(5, 5)));
    wr_reg(2'd2, 32'h0000_5678);
    read_word(5, 1, w, c);
    check("R5 R6 high after new ctl ignored", 64'(w), 64'(pat(5, 5)));

    // R6 high without low
    wr_reg(2'd0, {16'h0, 8'h3C, 1'b0, 7'd9});
    wr_reg(2'd2, 32'h0000_BEEF);
    read_word(9, 2, w, c);
    check("R6 high without low", 64'(w), 64'(pat(9, 5)));
    // R6 a second high after a commit is also ignored
    write_word(9, pat(9, 77), 16'h0);
    wr_reg(2'd2, 32'h0000_FFFF);
    read_word(9, 0, w, c);
    check("R6 repeat high", 64'(w), 64'(pat(9, 77)));

    // R2 lock; address bits in the same write are ignored
    wr_reg(2'd0, 32'h0000_AAB3);
    check("R2 match_en set", 64'(match_en), 64'h1);
    for (int s = 0; s < 4; s++) begin
      rd_reg(2'(s), v);
      check("R3 locked read", 64'(v), 64'h80);
    end
    wr_reg(2'd1, 32'h0000_1111);
    wr_reg(2'd2, 32'h0000_2222);

    // R9 matcher sweep
    for (int a = 0; a < NWORDS; a++) begin
      @(negedge clk);
      match_addr = 7'(a);
      @(negedge clk);
      check("R9 matcher word", 64'(match_rdata), 64'(a == 9 ? pat(9, 77) : pat(a, 5)));
    end

    // R2 unlock, data writes under lock had no effect
    wr_reg(2'd0, {24'h0, 1'b0, 7'd9});
    check("R2 match_en clear", 64'(match_en), 64'h0);
    read_word(9, 1, w, c);
    check("R2 locked writes ignored", 64'(w), 64'(pat(9, 77)));
    read_word(127, 2, w, c);
    check("R7 top address", 64'(w), 64'(pat(127, 5)));
    check("R7 top address field", 64'(c), 64'd127);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule